// File: doc/BRIEF.md
# Global Counter with Compare Interrupt

This block keeps a free-running 64-bit counter shared by the rest of the chip and compares it with a 64-bit compare value. When the two are equal it latches a pending interrupt. A routing register sends that interrupt to one of several output pins. Software reaches everything through a simple register bus. The bus carries 64-bit data and has a width flag, so the counter and the compare value can each be accessed as one 64-bit word or as two 32-bit halves.

Counting advances on every clock where the `cnt_en` input is high, unless a hold bit in the configuration register is set. A 32-bit read of the low counter half copies the high half into a shadow register. A later 32-bit read of the high half returns that copy, so two narrow reads give a consistent 64-bit snapshot even when a carry crosses between them.

Register offsets, in bytes: configuration 0x00, counter low 0x10, counter high 0x14, compare low 0x20, compare high 0x24, routing 0x30. A wide access (`bus_wide`=1) has meaning only at 0x10 and 0x20. Everywhere else it behaves as a 32-bit access.

Top module: `gcnt_timer`

## Requirements
- R1: After reset: the counter is 0, the compare value is all ones, the hold bit is 0, routing is disabled and every `irq_out` bit is 0.
- R2: While `cnt_en` is 1, the hold bit is 0 and no counter write occurs, the counter increases by exactly one per clock. While `cnt_en` is 0 the counter keeps its value.
- R3: While bit 28 of the configuration register (hold) is 1, the counter does not change. The bit reads back as written.
- R4: Bits 27:24 of the configuration register are read-only and report the counter width code (width-32)/4. This code is 8 for the 64-bit counter, and writes to these bits have no effect on the read value.
- R5: Incrementing from all ones gives zero.
- R6: A wide write at 0x10 loads all 64 counter bits. A wide read at 0x10 returns all 64 bits, and the same holds for the compare value at 0x20.
- R7: A 32-bit write at 0x10 changes only counter bits 31:0, and a 32-bit write at 0x14 changes only bits 63:32. Each takes its data from `bus_wdata[31:0]`.
- R8: A 32-bit read at 0x10 stores counter bits 63:32 in a shadow register. A 32-bit read at 0x14 returns that shadow, not the live high half.
- R9: The pending flag sets on a clock where the counter equals the compare value and stays set after the counter moves on. It clears on any write to the compare value (0x20 or 0x24), and the clear wins over a match on the same clock.
- R10: The routing register holds an enable in bit 31 and a pin number in bits 5:0. `irq_out[p]` is 1 one clock after the pending flag is 1 with routing enabled and pin p selected. Pin numbers at or above the number of outputs drive no output.
- R11: A counter write on a clock where counting is enabled loads the written value, with no increment on that clock.
- R12: Read data is registered and appears on `bus_rdata` on the clock after `bus_rd`. A 32-bit read fills bits 31:0 with zeros above, and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable, one increment per clock while high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 64 | Write data (32-bit accesses use bits 31:0) |
| bus_rdata | output | 64 | Registered read data |
| cnt_value | output | 64 | Current counter value |
| irq_out | output | 8 | Routed compare interrupt, one bit per pin |

## Verification
The hardest case to reach from the ports is a narrow read pair that straddles a carry out of the low half. In that case the shadow must return the old high half while the live counter has already moved on. The bench loads the counter two steps below a low-half rollover with counting stopped. It then enables counting in the same cycle as the low read and issues the high read after the carry, so the shadow and the live value differ. The compare path is driven by stepping the counter onto the compare value a known number of cycles, then checking that the interrupt appears exactly two clocks later and persists until the compare value is rewritten.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;
  localparam int GC_WORD_W   = 64;
  localparam int GC_HALF_W   = GC_WORD_W / 2;
  localparam int GC_ADDR_W   = 8;
  localparam int GC_PIN_W    = 6;

  localparam logic [GC_ADDR_W-1:0] OFS_CFG    = 8'h00;
  localparam logic [GC_ADDR_W-1:0] OFS_CNT_LO = 8'h10;
  localparam logic [GC_ADDR_W-1:0] OFS_CNT_HI = 8'h14;
  localparam logic [GC_ADDR_W-1:0] OFS_CMP_LO = 8'h20;
  localparam logic [GC_ADDR_W-1:0] OFS_CMP_HI = 8'h24;
  localparam logic [GC_ADDR_W-1:0] OFS_ROUTE  = 8'h30;

  localparam int CFG_HOLD_BIT  = 28;
  localparam int CFG_WCODE_LSB = 24;
  localparam int ROUTE_EN_BIT  = 31;

  typedef struct packed {
    logic                 lo_we;
    logic                 hi_we;
    logic [GC_HALF_W-1:0] lo_d;
    logic [GC_HALF_W-1:0] hi_d;
  } half_wr_t;

  function automatic logic [GC_WORD_W-1:0] merge_halves(
      input logic [GC_WORD_W-1:0] old_v, input half_wr_t w);
    logic [GC_WORD_W-1:0] r;
    r = old_v;
    if (w.lo_we) r[GC_HALF_W-1:0] = w.lo_d;
    if (w.hi_we) r[GC_WORD_W-1:GC_HALF_W] = w.hi_d;
    return r;
  endfunction

  function automatic half_wr_t decode_pair(
      input logic wr, input logic wide,
      input logic [GC_ADDR_W-1:0] addr, input logic [GC_ADDR_W-1:0] lo_ofs,
      input logic [GC_ADDR_W-1:0] hi_ofs, input logic [GC_WORD_W-1:0] wd);
    half_wr_t h;
    h.lo_we = wr && (addr == lo_ofs);
    h.hi_we = wr && ((addr == hi_ofs) || (wide && addr == lo_ofs));
    h.lo_d  = wd[GC_HALF_W-1:0];
    h.hi_d  = (wide && addr == lo_ofs) ? wd[GC_WORD_W-1:GC_HALF_W] : wd[GC_HALF_W-1:0];
    return h;
  endfunction
endpackage

// File: rtl/gcnt_counter.sv
module gcnt_counter
  import gcnt_pkg::*;
#(
  parameter int WORD_W = GC_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  half_wr_t          wr,
  output logic [WORD_W-1:0] cnt_q
);
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr.lo_we || wr.hi_we) begin
      cnt_q <= merge_halves(cnt_q, wr);
    end else if (tick) begin
      cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/gcnt_regs.sv
module gcnt_regs
  import gcnt_pkg::*;
#(
  parameter int WORD_W = GC_WORD_W,
  parameter int ADDR_W = GC_ADDR_W,
  parameter int PIN_W  = GC_PIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_wide,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] cnt_q,
  output logic [WORD_W-1:0] bus_rdata,
  output half_wr_t          cnt_wr,
  output logic [WORD_W-1:0] cmp_q,
  output logic              cmp_wr,
  output logic              hold_q,
  output logic              route_en_q,
  output logic [PIN_W-1:0]  route_pin_q
);
  localparam int HALF_W = WORD_W / 2;
  localparam logic [3:0] WCODE = 4'((WORD_W - 32) / 4);

  half_wr_t            cmp_hw;
  logic [HALF_W-1:0]   shadow_q;
  logic [WORD_W-1:0]   rd_next;
  logic [HALF_W-1:0]   cfg_word;
  logic [HALF_W-1:0]   route_word;

  always_comb begin
    cnt_wr = decode_pair(bus_wr, bus_wide, bus_addr, OFS_CNT_LO, OFS_CNT_HI, bus_wdata);
    cmp_hw = decode_pair(bus_wr, bus_wide, bus_addr, OFS_CMP_LO, OFS_CMP_HI, bus_wdata);
    cmp_wr = cmp_hw.lo_we || cmp_hw.hi_we;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q       <= '1;
      hold_q      <= 1'b0;
      route_en_q  <= 1'b0;
      route_pin_q <= '0;
    end else begin
      if (cmp_wr) cmp_q <= merge_halves(cmp_q, cmp_hw);
      if (bus_wr && bus_addr == OFS_CFG) hold_q <= bus_wdata[CFG_HOLD_BIT];
      if (bus_wr && bus_addr == OFS_ROUTE) begin
        route_en_q  <= bus_wdata[ROUTE_EN_BIT];
        route_pin_q <= bus_wdata[PIN_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
    end else if (bus_rd && !bus_wide && bus_addr == OFS_CNT_LO) begin
      shadow_q <= cnt_q[WORD_W-1:HALF_W];
    end
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[CFG_HOLD_BIT] = hold_q;
    cfg_word[CFG_WCODE_LSB +: 4] = WCODE;
    route_word = '0;
    route_word[ROUTE_EN_BIT] = route_en_q;
    route_word[PIN_W-1:0] = route_pin_q;
    unique case (bus_addr)
      OFS_CFG:    rd_next = {{HALF_W{1'b0}}, cfg_word};
      OFS_CNT_LO: rd_next = bus_wide ? cnt_q : {{HALF_W{1'b0}}, cnt_q[HALF_W-1:0]};
      OFS_CNT_HI: rd_next = {{HALF_W{1'b0}}, shadow_q};
      OFS_CMP_LO: rd_next = bus_wide ? cmp_q : {{HALF_W{1'b0}}, cmp_q[HALF_W-1:0]};
      OFS_CMP_HI: rd_next = {{HALF_W{1'b0}}, cmp_q[WORD_W-1:HALF_W]};
      OFS_ROUTE:  rd_next = {{HALF_W{1'b0}}, route_word};
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/gcnt_match.sv
module gcnt_match
  import gcnt_pkg::*;
#(
  parameter int WORD_W   = GC_WORD_W,
  parameter int PIN_W    = GC_PIN_W,
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [WORD_W-1:0]   cnt_q,
  input  logic [WORD_W-1:0]   cmp_q,
  input  logic                cmp_wr,
  input  logic                route_en,
  input  logic [PIN_W-1:0]    route_pin,
  output logic                pend_q,
  output logic [NUM_PINS-1:0] irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (cmp_wr) begin
      pend_q <= 1'b0;
    end else if (cnt_q == cmp_q) begin
      pend_q <= 1'b1;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        irq_q[p] <= 1'b0;
      end else begin
        irq_q[p] <= pend_q && route_en && (route_pin == PIN_W'(p));
      end
    end
  end
endmodule

// File: rtl/gcnt_timer.sv
module gcnt_timer
  import gcnt_pkg::*;
#(
  parameter int WORD_W   = GC_WORD_W,
  parameter int ADDR_W   = GC_ADDR_W,
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cnt_en,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic                bus_wide,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic [WORD_W-1:0]   cnt_value,
  output logic [NUM_PINS-1:0] irq_out
);
  localparam int PIN_W = GC_PIN_W;

  half_wr_t            cnt_wr;
  logic [WORD_W-1:0]   cmp_q;
  logic                cmp_wr;
  logic                hold;
  logic                route_en;
  logic [PIN_W-1:0]    route_pin;
  logic                pend;

  gcnt_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_q(cnt_value),
    .bus_rdata(bus_rdata), .cnt_wr(cnt_wr), .cmp_q(cmp_q), .cmp_wr(cmp_wr),
    .hold_q(hold), .route_en_q(route_en), .route_pin_q(route_pin)
  );

  gcnt_counter #(.WORD_W(WORD_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(cnt_en && !hold), .wr(cnt_wr), .cnt_q(cnt_value)
  );

  gcnt_match #(.WORD_W(WORD_W), .PIN_W(PIN_W), .NUM_PINS(NUM_PINS)) u_match (
    .clk(clk), .rst(rst), .cnt_q(cnt_value), .cmp_q(cmp_q), .cmp_wr(cmp_wr),
    .route_en(route_en), .route_pin(route_pin), .pend_q(pend), .irq_q(irq_out)
  );
endmodule

// File: rtl/gcnt_timer_chk.sv
module gcnt_timer_chk
  import gcnt_pkg::*;
#(
  parameter int WORD_W   = GC_WORD_W,
  parameter int ADDR_W   = GC_ADDR_W,
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                cnt_en,
  input logic                bus_wr,
  input logic                bus_wide,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [WORD_W-1:0]   bus_wdata,
  input logic [WORD_W-1:0]   cnt_value,
  input logic [NUM_PINS-1:0] irq_out,
  input logic                hold,
  input logic                pend
);
  logic cnt_touch;
  logic cmp_touch;
  assign cnt_touch = bus_wr && (bus_addr == OFS_CNT_LO || bus_addr == OFS_CNT_HI);
  assign cmp_touch = bus_wr && (bus_addr == OFS_CMP_LO || bus_addr == OFS_CMP_HI);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cnt_value == '0 && irq_out == '0));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !hold && !cnt_touch) |=> (cnt_value == $past(cnt_value) + WORD_W'(1)));

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
    ((hold || !cnt_en) && !cnt_touch) |=> $stable(cnt_value));

  assert_pend_clear_R9: assert property (@(posedge clk) disable iff (rst)
    cmp_touch |=> !pend);

  assert_irq_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_out));

  assert_irq_from_pend_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_out != '0) |-> $past(pend));

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_wide && bus_addr == OFS_CNT_LO) |=> (cnt_value == $past(bus_wdata)));
endmodule

bind gcnt_timer gcnt_timer_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .bus_wr(bus_wr), .bus_wide(bus_wide),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_value(cnt_value),
  .irq_out(irq_out), .hold(hold), .pend(pend)
);

// File: tb/gcnt_timer_bench.sv
`timescale 1ns/1ps
module gcnt_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  localparam int VW = 1 + 1 + 8 + 64 + 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wide = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [63:0] cnt_value;
  logic [7:0]  irq_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gcnt_timer u_gcnt_timer (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cnt_value(cnt_value), .irq_out(irq_out)
  );

  // vector: {is_write, wide, addr, data, expected read}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'h10, 64'h0123_4567_89AB_CDEF, 64'h0},
    {1'b0, 1'b1, 8'h10, 64'h0, 64'h0123_4567_89AB_CDEF},
    {1'b1, 1'b0, 8'h14, 64'h0000_0000_DEAD_BEEF, 64'h0},
    {1'b0, 1'b1, 8'h10, 64'h0, 64'hDEAD_BEEF_89AB_CDEF},
    {1'b1, 1'b0, 8'h10, 64'h0000_0000_1111_2222, 64'h0},
    {1'b0, 1'b1, 8'h10, 64'h0, 64'hDEAD_BEEF_1111_2222},
    {1'b0, 1'b0, 8'h00, 64'h0, 64'h0000_0000_0800_0000},
    {1'b1, 1'b0, 8'h00, 64'h0000_0000_0F00_0000, 64'h0},
    {1'b0, 1'b0, 8'h00, 64'h0, 64'h0000_0000_0800_0000},
    {1'b0, 1'b0, 8'h3C, 64'h0, 64'h0},
    {1'b1, 1'b1, 8'h20, 64'h0F0F_0000_1234_5678, 64'h0},
    {1'b0, 1'b1, 8'h20, 64'h0, 64'h0F0F_0000_1234_5678},
    {1'b1, 1'b0, 8'h30, 64'h0000_0000_7FFF_FFFF, 64'h0},
    {1'b0, 1'b0, 8'h30, 64'h0, 64'h0000_0000_0000_003F}
  };

  function automatic string vtag(input int i);
    case (i)
      1, 3:    return "R6";
      5:       return "R7";
      6, 8:    return "R4";
      9:       return "R12";
      11:      return "R6";
      13:      return "R10";
      default: return "none";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic w, input logic [63:0] d);
    bus_wr = 1'b1; bus_wide = w; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_wide = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic w, output logic [63:0] d);
    bus_rd = 1'b1; bus_wide = w; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0; bus_wide = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    logic [63:0] lo_rd;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    check("R1 counter", cnt_value, 64'h0);
    check("R1 irq", {56'h0, irq_out}, 64'h0);
    bus_read(8'h20, 1'b1, rd);
    check("R1 compare", rd, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_read(8'h00, 1'b0, rd);
    check("R1 config", rd, 64'h0000_0000_0800_0000);

    // table walk (counting stopped)
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      if (v[VW-1]) bus_write(v[VW-3 -: 8], v[VW-2], v[127:64]);
      else begin
        bus_read(v[VW-3 -: 8], v[VW-2], rd);
        check(vtag(i), rd, v[63:0]);
      end
    end

    // R2: counting
    bus_write(8'h10, 1'b1, 64'd100);
    cnt_en = 1'b1; idle(5); cnt_en = 1'b0;
    check("R2 five ticks", cnt_value, 64'd105);
    idle(3);
    check("R2 idle hold", cnt_value, 64'd105);

    // R3: hold bit
    bus_write(8'h00, 1'b0, 64'h1000_0000);
    cnt_en = 1'b1; idle(5); cnt_en = 1'b0;
    check("R3 held", cnt_value, 64'd105);
    bus_read(8'h00, 1'b0, rd);
    check("R3 readback", rd, 64'h0000_0000_1800_0000);
    bus_write(8'h00, 1'b0, 64'h0);

    // R5: wrap
    bus_write(8'h10, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    cnt_en = 1'b1; idle(1); cnt_en = 1'b0;
    check("R5 wrap", cnt_value, 64'h0);

    // R11: write beats increment
    cnt_en = 1'b1;
    bus_write(8'h10, 1'b1, 64'd500);
    check("R11 loaded", cnt_value, 64'd500);
    idle(1);
    check("R11 then counts", cnt_value, 64'd501);
    cnt_en = 1'b0;

    // R8: shadow across a low-half carry
    bus_write(8'h10, 1'b1, 64'h0000_0005_FFFF_FFFE);
    cnt_en = 1'b1;
    bus_read(8'h10, 1'b0, lo_rd);
    idle(1);
    bus_read(8'h14, 1'b0, rd);
    cnt_en = 1'b0;
    check("R8 low half", lo_rd, 64'h0000_0000_FFFF_FFFE);
    check("R8 shadow high", rd, 64'h0000_0000_0000_0005);
    check("R8 live high moved", {32'h0, cnt_value[63:32]}, 64'h6);

    // R9 / R10: match, sticky pending, routing
    bus_write(8'h30, 1'b0, 64'h8000_0002);
    bus_write(8'h20, 1'b1, 64'd50);
    bus_write(8'h10, 1'b1, 64'd48);
    cnt_en = 1'b1; idle(2); cnt_en = 1'b0;
    check("R9 at match", cnt_value, 64'd50);
    check("R9 no irq yet", {56'h0, irq_out}, 64'h0);
    idle(1);
    check("R10 one clock after pending", {56'h0, irq_out}, 64'h0);
    idle(1);
    check("R10 pin 2", {56'h0, irq_out}, 64'h04);
    bus_write(8'h10, 1'b1, 64'd1000);
    idle(1);
    check("R9 sticky", {56'h0, irq_out}, 64'h04);
    bus_write(8'h30, 1'b0, 64'h0000_0002);
    idle(1);
    check("R10 disabled", {56'h0, irq_out}, 64'h0);
    bus_write(8'h30, 1'b0, 64'h8000_0009);
    idle(1);
    check("R10 pin out of range", {56'h0, irq_out}, 64'h0);
    bus_write(8'h30, 1'b0, 64'h8000_0005);
    idle(1);
    check("R10 pin 5", {56'h0, irq_out}, 64'h20);
    bus_write(8'h24, 1'b0, 64'h0);
    idle(1);
    check("R9 cleared by compare write", {56'h0, irq_out}, 64'h0);
    bus_read(8'h20, 1'b1, rd);
    check("R7 compare high half write", rd, 64'd50);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule